// File: doc/BRIEF.md
# FSK Carrier Offset Tracking Loop

This block follows the carrier frequency offset between a remote transmitter and the local receiver in a 2-FSK, GFSK or MSK receive path. Each valid sample brings a signed frequency error: the discriminator output minus the current centre estimate. The loop scales that error by an arithmetic right shift and adds it to a signed offset estimate. The estimate therefore settles on the centre of the received deviation. Software reads the estimate at `est_out` and copies it into the synthesizer's offset trim.

The gain can be set separately for the time before sync detection and the time after it. A large gain settles quickly but follows noise. A small gain settles slowly but stays quiet. The estimate saturates at a programmable fraction of a channel-bandwidth word. An optional gate holds the loop still until carrier sense has been seen, so idle noise cannot push the estimate out to its limits. A synchronous clear returns the loop to zero at the start of each receive.

Top module: `fsk_offset_tracker`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `est_out` is 0. `clr` also closes the carrier gate again.
- R2: `freq_err` and `est_out` are two's complement. A sample with `sample_valid` high, an open gate and a nonzero gain adds `freq_err >>> shift` (arithmetic shift, rounding toward minus infinity) to the estimate. The new value appears on `est_out` one cycle later.
- R3: While `sync_found` is low, `pre_gain` codes 0, 1, 2 and 3 select shifts of 2, 3, 4 and 5.
- R4: While `sync_found` is high, `post_gain` code 0 freezes the estimate, and codes 1, 2 and 3 select shifts of 2, 3 and 4. When `sync_found` drops, `pre_gain` applies again from that cycle.
- R5: `limit_sel` codes 1, 2 and 3 set a limit L of `bw_word>>3`, `bw_word>>2` and `bw_word>>1`. Every cycle the estimate is clamped to [-L, +L]: it saturates rather than wraps, and it is pulled in when L shrinks.
- R6: `limit_sel` code 0 disables compensation. `est_out` is 0 in the cycle after.
- R7: With `gate_en` high, samples leave the estimate unchanged until `carrier_sense` is high. A sample in the same cycle as carrier sense already counts. From then on the gate stays open until `clr`.
- R8: With `sample_valid` low, the estimate holds, apart from the clamp of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear at start of receive |
| sample_valid | input | 1 | `freq_err` is valid this cycle |
| freq_err | input | ERR_W | Signed instantaneous frequency error |
| sync_found | input | 1 | Sync word has been detected |
| carrier_sense | input | 1 | Carrier sense flag |
| gate_en | input | 1 | Freeze the loop until carrier sense is seen |
| pre_gain | input | 2 | Gain code used before sync |
| post_gain | input | 2 | Gain code used after sync |
| limit_sel | input | 2 | Tracking limit code |
| bw_word | input | BW_W | Unsigned channel bandwidth word |
| est_out | output | EST_W | Signed offset estimate |

## Verification
The estimate is the only registered result. Every stimulus (a sample, a clear, a limit change or a gain change) shows on `est_out` exactly one clock after the edge that captures it. The bench changes its inputs on the falling edge and compares `est_out` on the next falling edge, so exactly one rising edge lies between stimulus and check. A reference value is computed arithmetically for every step, from the shift rule, the clamp rule and the sticky gate flag.

// File: rtl/fot_pkg.sv
package fot_pkg;
   typedef enum logic [1:0] {
      LIM_OFF  = 2'd0,
      LIM_EIGHTH = 2'd1,
      LIM_QUARTER = 2'd2,
      LIM_HALF = 2'd3
   } lim_code_e;

   localparam int SHIFT_W = 3;

   // Pre-sync code c selects shift c+2.
   function automatic logic [SHIFT_W-1:0] pre_shift(input logic [1:0] code);
      return SHIFT_W'(code) + SHIFT_W'(2);
   endfunction

   // Post-sync code c (c>0) selects shift c+1; code 0 means no gain.
   function automatic logic [SHIFT_W-1:0] post_shift(input logic [1:0] code);
      return SHIFT_W'(code) + SHIFT_W'(1);
   endfunction
endpackage

// File: rtl/fot_gain_stage.sv
module fot_gain_stage import fot_pkg::*; #(
   parameter int ERR_W = 8
) (
   input  logic             sync_found,
   input  logic [1:0]       pre_gain,
   input  logic [1:0]       post_gain,
   input  logic [ERR_W-1:0] err_in,
   output logic             gain_on,
   output logic [ERR_W-1:0] delta
);
   logic [SHIFT_W-1:0] shamt;

   always_comb begin
      if (sync_found) begin
         gain_on = (post_gain != 2'd0);
         shamt   = post_shift(post_gain);
      end else begin
         gain_on = 1'b1;
         shamt   = pre_shift(pre_gain);
      end
      delta = ERR_W'($signed(err_in) >>> shamt);
   end
endmodule

// File: rtl/fot_limit.sv
module fot_limit import fot_pkg::*; #(
   parameter int BW_W  = 8,
   parameter int EST_W = 8
) (
   input  logic [BW_W-1:0]  bw_word,
   input  logic [1:0]       limit_sel,
   output logic             comp_on,
   output logic [EST_W-1:0] lim
);
   logic [EST_W-1:0] bw_ext;

   generate
      if (BW_W == EST_W) begin : g_same
         assign bw_ext = bw_word;
      end else begin : g_pad
         assign bw_ext = {{(EST_W-BW_W){1'b0}}, bw_word};
      end
   endgenerate

   always_comb begin
      comp_on = 1'b1;
      unique case (lim_code_e'(limit_sel))
         LIM_EIGHTH:  lim = bw_ext >> 3;
         LIM_QUARTER: lim = bw_ext >> 2;
         LIM_HALF:    lim = bw_ext >> 1;
         default: begin
            lim     = '0;
            comp_on = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/fot_sat_acc.sv
module fot_sat_acc #(
   parameter int ERR_W = 8,
   parameter int EST_W = 8
) (
   input  logic [EST_W-1:0] est_cur,
   input  logic [ERR_W-1:0] delta,
   input  logic             upd,
   input  logic [EST_W-1:0] lim,
   output logic [EST_W-1:0] est_nxt
);
   localparam int SUM_W = ((ERR_W > EST_W) ? ERR_W : EST_W) + 2;

   logic signed [SUM_W-1:0] est_w, dlt_w, sum, lim_p, lim_n;

   always_comb begin
      est_w = {{(SUM_W-EST_W){est_cur[EST_W-1]}}, est_cur};
      dlt_w = upd ? {{(SUM_W-ERR_W){delta[ERR_W-1]}}, delta} : '0;
      sum   = est_w + dlt_w;
      lim_p = {{(SUM_W-EST_W){1'b0}}, lim};
      lim_n = -lim_p;
      if (sum > lim_p)      est_nxt = lim_p[EST_W-1:0];
      else if (sum < lim_n) est_nxt = lim_n[EST_W-1:0];
      else                  est_nxt = sum[EST_W-1:0];
   end
endmodule

// File: rtl/fsk_offset_tracker.sv
module fsk_offset_tracker import fot_pkg::*; #(
   parameter int ERR_W = 8,
   parameter int EST_W = 8,
   parameter int BW_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sample_valid,
   input  logic [ERR_W-1:0] freq_err,
   input  logic             sync_found,
   input  logic             carrier_sense,
   input  logic             gate_en,
   input  logic [1:0]       pre_gain,
   input  logic [1:0]       post_gain,
   input  logic [1:0]       limit_sel,
   input  logic [BW_W-1:0]  bw_word,
   output logic [EST_W-1:0] est_out
);
   generate
      if (BW_W > EST_W) begin : g_chk_bw
         $error("BW_W must not exceed EST_W");
      end
      if (ERR_W < 6) begin : g_chk_err
         $error("ERR_W must be at least 6");
      end
   endgenerate

   logic             gain_on, comp_on, cs_seen_q, gate_open, upd;
   logic [ERR_W-1:0] delta;
   logic [EST_W-1:0] lim, est_q, est_nxt;

   fot_gain_stage #(.ERR_W(ERR_W)) u_gain (
      .sync_found(sync_found), .pre_gain(pre_gain), .post_gain(post_gain),
      .err_in(freq_err), .gain_on(gain_on), .delta(delta)
   );

   fot_limit #(.BW_W(BW_W), .EST_W(EST_W)) u_lim (
      .bw_word(bw_word), .limit_sel(limit_sel), .comp_on(comp_on), .lim(lim)
   );

   assign gate_open = !gate_en || cs_seen_q || carrier_sense;
   assign upd       = sample_valid && gate_open && gain_on;

   fot_sat_acc #(.ERR_W(ERR_W), .EST_W(EST_W)) u_acc (
      .est_cur(est_q), .delta(delta), .upd(upd), .lim(lim), .est_nxt(est_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q     <= '0;
         cs_seen_q <= 1'b0;
      end else begin
         cs_seen_q <= clr ? 1'b0 : (cs_seen_q || carrier_sense);
         if (clr || !comp_on) est_q <= '0;
         else                 est_q <= est_nxt;
      end
   end

   assign est_out = est_q;
endmodule

// File: rtl/fot_checker.sv
module fot_checker #(
   parameter int ERR_W = 8,
   parameter int EST_W = 8,
   parameter int BW_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             sample_valid,
   input logic [ERR_W-1:0] freq_err,
   input logic             sync_found,
   input logic             carrier_sense,
   input logic             gate_en,
   input logic [1:0]       pre_gain,
   input logic [1:0]       post_gain,
   input logic [1:0]       limit_sel,
   input logic [BW_W-1:0]  bw_word,
   input logic [EST_W-1:0] est_out
);
   int   est_i, lim_i;
   logic seen, in_lim, quiet_err;

   always_comb begin
      est_i     = int'($signed(est_out));
      lim_i     = (limit_sel == 2'd0) ? 0 : int'(bw_word >> (4 - int'(limit_sel)));
      in_lim    = (est_i <= lim_i) && (est_i >= -lim_i);
      quiet_err = (freq_err == '0) && (pre_gain == 2'd0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= clr ? 1'b0 : (seen || carrier_sense);
   end

   a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (est_out == '0));

   a_r6_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_sel == 2'd0) |=> (est_out == '0));

   a_r5_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && limit_sel != 2'd0) |=>
         (est_i <= $past(lim_i) && est_i >= -$past(lim_i)));

   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid && !clr && limit_sel != 2'd0 && in_lim) |=> $stable(est_out));

   a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !seen && !carrier_sense && !clr && limit_sel != 2'd0 && in_lim)
         |=> $stable(est_out));

   a_r4_post_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_found && post_gain == 2'd0 && !clr && limit_sel != 2'd0 && in_lim)
         |=> $stable(est_out));

   a_r3_zero_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_err && !sync_found && !clr && limit_sel != 2'd0 && in_lim)
         |=> $stable(est_out));
endmodule

bind fsk_offset_tracker fot_checker #(.ERR_W(ERR_W), .EST_W(EST_W), .BW_W(BW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .sample_valid(sample_valid),
   .freq_err(freq_err), .sync_found(sync_found), .carrier_sense(carrier_sense),
   .gate_en(gate_en), .pre_gain(pre_gain), .post_gain(post_gain),
   .limit_sel(limit_sel), .bw_word(bw_word), .est_out(est_out)
);

// File: tb/fsk_offset_tracker_tb.sv
module fsk_offset_tracker_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0, rst_n = 1'b0, clr = 1'b0, sample_valid = 1'b0;
   logic [7:0] freq_err = '0;
   logic       sync_found = 1'b0, carrier_sense = 1'b0, gate_en = 1'b0;
   logic [1:0] pre_gain = '0, post_gain = '0, limit_sel = 2'd3;
   logic [7:0] bw_word = 8'd240;
   logic [7:0] est_out;

   int total = 0, bad = 0;
   int m_est = 0;
   bit m_seen = 0;
   bit done = 0;

   fsk_offset_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .sample_valid(sample_valid),
      .freq_err(freq_err), .sync_found(sync_found), .carrier_sense(carrier_sense),
      .gate_en(gate_en), .pre_gain(pre_gain), .post_gain(post_gain),
      .limit_sel(limit_sel), .bw_word(bw_word), .est_out(est_out)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string tag);
      int act;
      act = int'($signed(est_out));
      total++;
      if (act != m_est) begin
         bad++;
         $display("FAIL %s: est_out=%0d expected=%0d", tag, act, m_est);
      end
   endtask

   // Called at a falling edge: drive, advance model, compare at next falling edge.
   task automatic step(input bit v, input int err, input bit c, input string tag);
      int sh, lim, sum;
      bit gain_on, open;
      sample_valid = v; freq_err = 8'(err); clr = c;
      if (sync_found) begin gain_on = (post_gain != 0); sh = int'(post_gain) + 1; end
      else begin gain_on = 1; sh = int'(pre_gain) + 2; end
      open = !gate_en || m_seen || carrier_sense;
      lim = (limit_sel == 0) ? 0 : int'(bw_word) >> (4 - int'(limit_sel));
      sum = m_est + ((v && open && gain_on) ? (err >>> sh) : 0);
      if (sum > lim) sum = lim;
      if (sum < -lim) sum = -lim;
      m_est  = (c || limit_sel == 0) ? 0 : sum;
      m_seen = c ? 0 : (m_seen || carrier_sense);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      #(CLK_P*20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: expired, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int errs[8] = '{100, -100, 37, -37, 1, -1, 127, -128};
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R3: all pre-sync gains against several error values
      for (int g = 0; g < 4; g++) begin
         pre_gain = 2'(g);
         foreach (errs[i]) begin
            step(0, 0, 1, "R1 clear");
            step(1, errs[i], 0, "R3 pre gain");
            step(1, errs[i], 0, "R2 accumulate");
         end
      end

      // R4: post-sync gains including freeze
      sync_found = 1'b1;
      for (int g = 0; g < 4; g++) begin
         post_gain = 2'(g);
         foreach (errs[i]) begin
            step(0, 0, 1, "R1 clear");
            step(1, errs[i], 0, "R4 post gain");
            step(1, errs[i], 0, "R4 post gain second");
         end
      end
      // R4: drop of sync returns to pre gain
      post_gain = 2'd0; pre_gain = 2'd0;
      step(1, 80, 0, "R4 frozen after sync");
      sync_found = 1'b0;
      step(1, 80, 0, "R4 pre gain after sync drop");

      // R5: saturation at each limit, both signs
      for (int s = 1; s < 4; s++) begin
         limit_sel = 2'(s);
         step(0, 0, 1, "R1 clear");
         for (int k = 0; k < 6; k++) step(1, 127, 0, "R5 positive saturate");
         for (int k = 0; k < 10; k++) step(1, -128, 0, "R5 negative saturate");
      end
      // R5: shrinking limit pulls estimate inward
      limit_sel = 2'd3;
      step(0, 0, 1, "R1 clear");
      for (int k = 0; k < 6; k++) step(1, 127, 0, "R5 fill");
      limit_sel = 2'd1;
      step(0, 0, 0, "R5 shrink clamp");
      bw_word = 8'd64;
      limit_sel = 2'd2;
      step(0, 0, 0, "R5 new bw clamp");
      bw_word = 8'd240;

      // R8: idle holds
      limit_sel = 2'd3;
      step(1, -90, 0, "R2 accumulate");
      for (int k = 0; k < 4; k++) step(0, 120, 0, "R8 invalid sample ignored");

      // R6: compensation off
      limit_sel = 2'd0;
      step(1, 100, 0, "R6 off");
      step(1, 100, 0, "R6 off held zero");
      limit_sel = 2'd3;
      step(1, 100, 0, "R6 re-enabled");

      // R7: gate
      gate_en = 1'b1;
      step(0, 0, 1, "R1 clear closes gate");
      for (int k = 0; k < 3; k++) step(1, 100, 0, "R7 gate closed");
      carrier_sense = 1'b1;
      step(1, 100, 0, "R7 same cycle carrier");
      carrier_sense = 1'b0;
      step(1, -60, 0, "R7 gate stays open");
      step(1, 40, 1, "R1 clear mid-run");
      step(1, 100, 0, "R7 gate closed after clear");
      gate_en = 1'b0;
      step(1, 100, 0, "R7 gate disabled");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule